// File: doc/BRIEF.md
# Gated Dual Event Counter with Duty-Cycle Gate Generator

This block holds two event counters whose count inputs pass through a single gate. A duty-cycle generator drives the gate: each cycle of the gate lasts a programmable number of clock periods. The gate is low for a programmable off time at the start of the cycle and high for the rest. While the gate is low, neither counter accepts events. Software can therefore let both counters sample events in a repeating window without touching them. When the generator is disabled, the gate stays high and the counters count freely.

The gate is also an interrupt source. An edge detector with a selectable sense (falling, rising, both or none) sets a sticky request flag. An interrupt request leaves the block while that flag is set and the interrupt enable is on. Configuration is written one byte at a time over a small write port. The off-time value must be below the period value whenever the generator is enabled. The exception is the all-ones off time, which parks the gate low.

Top module: `pgec_top`

## Requirements
- R1: After a synchronous reset, `gate` is 1, `flag` and `irq` are 0, both counters read 0, and the generator is disabled.
- R2: While the enable bit (control byte bit 0) is 0, `gate` is 1 and each counter increments by one on every clock in which its event input is 1.
- R3: While enabled, the gate repeats with a cycle of P+1 clocks, where P is the 16-bit period value. The gate is low for the first D+1 clocks of each cycle, where D is the 16-bit off-time value, and high for the remaining P-D clocks.
- R4: While enabled with D equal to 16'hFFFF, `gate` stays 0 on every clock.
- R5: A counter increments only on clocks where both its event input and the shared `gate` are 1. Neither counter moves while `gate` is 0.
- R6: Control bits 2:1 choose the edge sense: 2'b00 falling, 2'b01 rising, 2'b10 both, 2'b11 none. A selected edge of `gate` sets `flag` on the following clock.
- R7: `flag` stays set until a write to address 5 with data bit 0 equal to 0. Writing 1 in that bit has no effect, and the interrupt enable has no influence on the flag.
- R8: `irq` is 1 exactly while `flag` is 1 and the interrupt enable (control byte bit 3) is 1.
- R9: Byte writes go to these addresses: 0 period low, 1 period high, 2 off-time low, 3 off-time high, 4 control, 5 flag. Each write takes effect on the clock that captures it.
- R10: Each transition of the enable from 0 to 1 restarts the gate cycle at the start of its off window, even if the previous run stopped partway through a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the time base of the gate cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write byte |
| evt_a | input | 1 | Event input of counter A |
| evt_b | input | 1 | Event input of counter B |
| gate | output | 1 | Shared count gate |
| flag | output | 1 | Sticky edge request flag |
| irq | output | 1 | Interrupt request |
| cnt_a | output | 8 | Counter A value |
| cnt_b | output | 8 | Counter B value |

## Verification
A wrong cycle counter appears on `gate` within one gate cycle. The transition lands on the wrong clock, or the level fails to return to low at the wrap. Both show when the bench compares each clock against the expected cycle position. Counter deltas over a window expose a gate that is not shared or an event that leaks through a low window. A flag set on the wrong edge, or one clock late or early, is caught at single-clock resolution right after the gate transitions.

// File: rtl/pgec_pkg.sv
package pgec_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned TIME_W = 16;
    localparam int unsigned ADDR_W = 3;

    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_SNS_LSB = 1;
    localparam int unsigned CTRL_IE_BIT  = 3;

    typedef enum logic [1:0] {
        SENSE_FALL = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_BOTH = 2'b10,
        SENSE_NONE = 2'b11
    } sense_e;

    typedef enum logic [ADDR_W-1:0] {
        A_PER_LO = 3'd0,
        A_PER_HI = 3'd1,
        A_OFF_LO = 3'd2,
        A_OFF_HI = 3'd3,
        A_CTRL   = 3'd4,
        A_FLAG   = 3'd5
    } addr_e;

    typedef struct packed {
        logic [TIME_W-1:0] period;
        logic [TIME_W-1:0] off_time;
        logic              enable;
        sense_e            sense;
        logic              irq_en;
    } cfg_t;

    function automatic logic edge_hit(sense_e s, logic prev, logic cur);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = prev & ~cur;
        case (s)
            SENSE_FALL: edge_hit = fall;
            SENSE_RISE: edge_hit = rise;
            SENSE_BOTH: edge_hit = rise | fall;
            default:    edge_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pgec_regs.sv
module pgec_regs
    import pgec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output cfg_t              cfg,
    output logic              flag_clr
);

    localparam int unsigned HI_LSB = TIME_W - BYTE_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.period   <= '0;
            cfg.off_time <= '0;
            cfg.enable   <= 1'b0;
            cfg.sense    <= SENSE_FALL;
            cfg.irq_en   <= 1'b0;
        end else if (wr_en) begin
            case (addr_e'(wr_addr))
                A_PER_LO: cfg.period[BYTE_W-1:0]        <= wr_data;
                A_PER_HI: cfg.period[TIME_W-1:HI_LSB]   <= wr_data;
                A_OFF_LO: cfg.off_time[BYTE_W-1:0]      <= wr_data;
                A_OFF_HI: cfg.off_time[TIME_W-1:HI_LSB] <= wr_data;
                A_CTRL: begin
                    cfg.enable <= wr_data[CTRL_EN_BIT];
                    cfg.sense  <= sense_e'(wr_data[CTRL_SNS_LSB +: 2]);
                    cfg.irq_en <= wr_data[CTRL_IE_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        flag_clr = wr_en && (addr_e'(wr_addr) == A_FLAG) && !wr_data[0];
    end

endmodule

// File: rtl/pgec_gate_gen.sv
module pgec_gate_gen
    import pgec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [TIME_W-1:0] period,
    input  logic [TIME_W-1:0] off_time,
    output logic              gate
);

    localparam logic [TIME_W-1:0] PARK_LOW = '1;

    logic [TIME_W-1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cyc <= '0;
        end else if (cyc >= period) begin
            cyc <= '0;
        end else begin
            cyc <= cyc + TIME_W'(1);
        end
    end

    always_comb begin
        if (!enable) begin
            gate = 1'b1;
        end else if (off_time == PARK_LOW) begin
            gate = 1'b0;
        end else begin
            gate = (cyc > off_time);
        end
    end

    // R2: disabled generator leaves the gate open
    p_open_when_off_r2: assert property (@(posedge clk) disable iff (rst)
        !enable |-> gate);

    // R3: the cycle counter wraps to zero after reaching the period value
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (enable && cyc == period) |=> (cyc == '0));

    // R4: all-ones off time parks the gate low
    p_hold_low_r4: assert property (@(posedge clk) disable iff (rst)
        (enable && off_time == PARK_LOW) |-> !gate);

    // R10: a fresh enable starts inside the off window
    p_restart_r10: assert property (@(posedge clk) disable iff (rst)
        (enable && !$past(enable)) |-> !gate);

endmodule

// File: rtl/pgec_edge_flag.sv
module pgec_edge_flag
    import pgec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   gate,
    input  sense_e sense,
    input  logic   irq_en,
    input  logic   flag_clr,
    output logic   flag,
    output logic   irq
);

    logic gate_q;
    logic hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b1;
        end else begin
            gate_q <= gate;
        end
    end

    always_comb begin
        hit = edge_hit(sense, gate_q, gate);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    always_comb begin
        irq = flag & irq_en;
    end

    // R6: a rising gate edge under rising sense sets the flag next clock
    p_rise_sets_r6: assert property (@(posedge clk) disable iff (rst)
        (sense == SENSE_RISE && $rose(gate)) |=> flag);

    // R6: the reserved sense never sets the flag
    p_none_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (sense == SENSE_NONE && !flag) |=> !flag);

    // R7: without a clear request the flag stays set
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    // R8: no request leaves while the enable is off
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_en);

endmodule

// File: rtl/pgec_evt_counter.sv
module pgec_evt_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate,
    input  logic             evt,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (gate && evt) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R5: a closed gate freezes the counter
    p_gated_r5: assert property (@(posedge clk) disable iff (rst)
        !gate |=> $stable(cnt));

endmodule

// File: rtl/pgec_top.sv
module pgec_top
    import pgec_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              evt_a,
    input  logic              evt_b,
    output logic              gate,
    output logic              flag,
    output logic              irq,
    output logic [CNT_W-1:0]  cnt_a,
    output logic [CNT_W-1:0]  cnt_b
);

    localparam int unsigned N_CNT = 2;

    cfg_t             cfg;
    logic             flag_clr;
    logic [N_CNT-1:0] evt_vec;
    logic [CNT_W-1:0] cnt_arr [N_CNT];

    pgec_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg      (cfg),
        .flag_clr (flag_clr)
    );

    pgec_gate_gen u_gate (
        .clk      (clk),
        .rst      (rst),
        .enable   (cfg.enable),
        .period   (cfg.period),
        .off_time (cfg.off_time),
        .gate     (gate)
    );

    pgec_edge_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .gate     (gate),
        .sense    (cfg.sense),
        .irq_en   (cfg.irq_en),
        .flag_clr (flag_clr),
        .flag     (flag),
        .irq      (irq)
    );

    assign evt_vec = {evt_b, evt_a};

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        pgec_evt_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .gate (gate),
            .evt  (evt_vec[g]),
            .cnt  (cnt_arr[g])
        );
    end

    assign cnt_a = cnt_arr[0];
    assign cnt_b = cnt_arr[1];

endmodule

// File: tb/test_pgec_top.sv
module test_pgec_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       evt_a = 1'b0;
    logic       evt_b = 1'b0;
    logic       gate, flag, irq;
    logic [7:0] cnt_a, cnt_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit exp_q[$];
    int mon_idx  = 0;
    string mon_tag = "R3";

    always #4 clk = ~clk;

    pgec_top i_pgec_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .evt_a(evt_a), .evt_b(evt_b),
        .gate(gate), .flag(flag), .irq(irq), .cnt_a(cnt_a), .cnt_b(cnt_b)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops one expected gate level per clock, away from the edge
    always @(negedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            bit e;
            e = exp_q.pop_front();
            n_checks++;
            if (gate !== e) begin
                n_fail++;
                $display("FAIL %s: gate at step %0d actual %0b expected %0b",
                         mon_tag, mon_idx, gate, e);
            end
            mon_idx++;
        end
    end

    // returns at the falling edge right after the write was captured
    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] ctrl(bit en, logic [1:0] s, bit ie);
        return {4'b0, ie, s, en};
    endfunction

    function automatic bit exp_gate(int i, int d, int p);
        if (d == 16'hFFFF) return 1'b0;
        return ((i % (p + 1)) > d);
    endfunction

    // configure, enable, push expected gate levels, drive events on both counters
    task automatic run_gate(string tag, int d, int p, int len, logic [1:0] s, bit ie);
        logic [7:0] a0, b0;
        int ones;
        wr(3'd4, ctrl(0, 2'b11, ie));
        wr(3'd0, p[7:0]);  wr(3'd1, p[15:8]);
        wr(3'd2, d[7:0]);  wr(3'd3, d[15:8]);
        wr(3'd4, ctrl(1, s, ie));
        mon_tag = tag; mon_idx = 0; ones = 0;
        for (int i = 0; i < len; i++) begin
            bit e;
            e = exp_gate(i, d, p);
            exp_q.push_back(e);
            ones += e;
        end
        a0 = cnt_a; b0 = cnt_b;
        evt_a = 1'b1; evt_b = 1'b1;
        repeat (len) @(negedge clk);
        evt_a = 1'b0; evt_b = 1'b0;
        #2;
        check({tag, "/R5 cnt_a delta"}, 32'(8'(cnt_a - a0)), 32'(8'(ones)));
        check({tag, "/R5 cnt_b delta"}, 32'(8'(cnt_b - b0)), 32'(8'(ones)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] a0, b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R1 gate", gate, 1);
        check("R1 flag", flag, 0);
        check("R1 irq", irq, 0);
        check("R1 cnt_a", cnt_a, 0);
        check("R1 cnt_b", cnt_b, 0);

        // R2: disabled, free counting on A only
        @(negedge clk);
        a0 = cnt_a; b0 = cnt_b;
        evt_a = 1'b1;
        repeat (10) begin
            @(negedge clk); #1;
            check("R2 gate open", gate, 1);
        end
        evt_a = 1'b0;
        #1;
        check("R2 cnt_a free count", 32'(8'(cnt_a - a0)), 10);
        check("R2 cnt_b idle", 32'(8'(cnt_b - b0)), 0);

        // R3/R5: short cycle, several wraps
        run_gate("R3 d2 p5", 2, 5, 20, 2'b11, 0);
        // R10: previous run stopped mid-cycle; new run restarts in off window
        run_gate("R10 d0 p3", 0, 3, 11, 2'b11, 0);
        run_gate("R10 d6 p9", 6, 9, 27, 2'b11, 0);
        // R9: high bytes matter
        run_gate("R9 d258 p261", 16'h0102, 16'h0105, 600, 2'b11, 0);
        // R4: parked low
        run_gate("R4 park", 16'hFFFF, 16'h0010, 40, 2'b01, 0);
        check("R4/R6 no rise while parked", flag, 0);

        // R6: reserved sense over full cycles
        run_gate("R6 none", 1, 4, 15, 2'b11, 0);
        check("R6 reserved sense flag", flag, 0);

        // R6/R7/R8: rising sense, interrupt disabled
        run_gate("R6 rise", 1, 4, 15, 2'b01, 0);
        check("R7 flag set with ie=0", flag, 1);
        check("R8 irq masked", irq, 0);
        wr(3'd4, ctrl(1, 2'b11, 1));
        #1;
        check("R8 irq with ie=1", irq, 1);
        wr(3'd4, ctrl(0, 2'b11, 1));
        wr(3'd5, 8'h01);
        #1;
        check("R7 write 1 keeps flag", flag, 1);
        wr(3'd5, 8'h00);
        #1;
        check("R7 flag cleared", flag, 0);
        check("R8 irq follows flag", irq, 0);

        // R6: rising edge timing, d=2 p=5 -> gate rises at step 3, flag at step 4
        wr(3'd0, 8'd5); wr(3'd1, 8'd0); wr(3'd2, 8'd2); wr(3'd3, 8'd0);
        wr(3'd4, ctrl(1, 2'b01, 0));
        #1; check("R6 rise step0 flag", flag, 0);
        repeat (3) @(negedge clk);
        #1; check("R6 rise step3 gate", gate, 1);
        check("R6 rise step3 flag", flag, 0);
        @(negedge clk); #1;
        check("R6 rise step4 flag", flag, 1);

        // R6: falling sense, the enable itself closes the gate
        wr(3'd4, ctrl(0, 2'b11, 0));
        wr(3'd5, 8'h00);
        wr(3'd4, ctrl(1, 2'b00, 0));
        #1; check("R6 fall step0 gate", gate, 0);
        check("R6 fall step0 flag", flag, 0);
        @(negedge clk); #1;
        check("R6 fall step1 flag", flag, 1);

        // R6: both edges, clear after the falling edge, then rise sets again
        wr(3'd4, ctrl(0, 2'b11, 0));
        wr(3'd5, 8'h00);
        wr(3'd4, ctrl(1, 2'b10, 0));
        @(negedge clk); #1;
        check("R6 both fall flag", flag, 1);
        wr(3'd5, 8'h00);
        #1; check("R6 both cleared", flag, 0);
        @(negedge clk); #1;
        check("R6 both rise flag", flag, 1);

        wr(3'd4, ctrl(0, 2'b11, 0));
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule